// File: doc/BRIEF.md
# Serial Register Access Master

This block gives a host a simple way to read and write the 16-bit configuration registers of an Ethernet switch. The switch is reached over a three-wire serial link made of a chip-select line, a serial clock and one bidirectional data line. The data line is modelled here as separate output, output-enable and input signals. The host hands over one request at a time. A request carries a write flag, a register address and 16 bits of write data. The block builds the matching serial frame and shifts it out MSB-first. For a read it then turns the data line around and collects the reply.

All link timing comes from the system clock. The minimum clock-edge time is `CLK_MHZ*EDGE_US` system cycles and the data setup time is `CLK_MHZ*SETUP_US` system cycles, so the microsecond minimums hold at any clock frequency. The two kinds of frame behave differently. A read holds chip select low throughout. It sends a 46-bit command, releases the data line, and samples 32 bits that carry a pair of neighbouring registers. Address bit 0 picks which half goes back to the host. A write holds chip select high for a 27-bit frame. It then drops chip select and gives two more clock pulses.

The request side is a valid/ready port. The host keeps `req_valid` and the request fields steady until it sees `req_ready` high at a clock edge, and the transfer is taken at that edge. `req_ready` is high only while no transaction is running, so the link applies the back-pressure. The response side is a one-cycle `rsp_valid` pulse with no ready signal. The host cannot stall it. Instead, `rsp_rdata` stays steady until the next read completes.

Top module: `serreg_master`

## Requirements
- R1: A read command is 46 bits, sent MSB-first with chip select low. The bits are 32 ones, then `01`, then `10`, then `0`, then `00`, then address bits [6:0] MSB-first. Address bit 7 has no effect on a read.
- R2: After the read command tail, the data line is released (output enable 0). The block then gives 2 turnaround clock pulses, samples 32 data bits MSB-first, and gives 2 trailing pulses. Each pulse is high for E cycles and then low for E cycles.
- R3: A read returns the first 16 bits received when address bit 0 is 1, and the last 16 bits received when address bit 0 is 0.
- R4: A write frame is 27 bits, MSB-first: `1`, then `01`, then address[7:0], then data[15:0]. Chip select is high from the lead phase through the tail phase.
- R5: After the write tail, chip select goes low and 2 clock pulses follow. The data line is still driven with the last data bit during these pulses.
- R6: Every bit cell has the clock low for E cycles, then the new data (or the sample) with the clock low for S cycles, then the clock high for E cycles. E = CLK_MHZ*EDGE_US and S = CLK_MHZ*SETUP_US.
- R7: Before the first bit of a frame, chip select is set and held for E cycles with the clock low. After the last bit, the clock stays low for E cycles before chip select changes or the next step begins.
- R8: In the cycle after a request is accepted, chip select, clock and data are all driven, with clock and data at 0. When the transaction ends, chip select, clock and data are all released.
- R9: `req_ready` is high exactly when no transaction is running. While busy, `req_valid` and the request fields have no effect on the link.
- R10: `rsp_valid` is high for one cycle, right after the last trailing pulse of either kind of transaction. `rsp_rdata` changes only when a read completes, and a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address (bits [6:0] used for reads) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read result |
| cs_o | output | 1 | Chip-select level |
| cs_oe | output | 1 | Chip-select output enable |
| sck_o | output | 1 | Serial clock level |
| sck_oe | output | 1 | Serial clock output enable |
| sd_o | output | 1 | Serial data driven value |
| sd_oe | output | 1 | Serial data output enable |
| sd_i | input | 1 | Serial data sampled value |

## Verification
Most internal faults in this block show up on the link pins within one bit cell. A wrong phase timer stretches or shortens the very first lead phase. A wrong bit counter moves the tail, and with it the chip-select drop or the data-line release, by a whole cell. A shift register that is out of step puts a wrong data bit on the line in the setup phase where it happens. Capture-order or half-select faults are hidden until the completion pulse, and then show at once in `rsp_rdata`. The reference model therefore rebuilds the expected pin levels for every clock cycle and compares them each cycle.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

  // Frame geometry of the serial link
  localparam int PREAMBLE_BITS = 32;
  localparam int RD_CMD_BITS   = 46;
  localparam int WR_CMD_BITS   = 27;
  localparam int CAPT_BITS     = 32;
  localparam int REG_W         = 16;
  localparam int ADDR_W        = 8;
  localparam int EXTRA_CLKS    = 2;
  localparam int BC_W          = $clog2(RD_CMD_BITS + 1);

  // Timing phase of the link
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,   // chip select settled, clock low
    PH_LOW,    // bit cell: clock low
    PH_SETUP,  // bit cell: data presented / sampled, clock low
    PH_HIGH,   // bit cell: clock high
    PH_TAIL,   // clock low after final bit
    PH_PHIGH,  // extra pulse: clock high
    PH_PLOW    // extra pulse: clock low
  } phase_e;

  // Which part of a transaction is running
  typedef enum logic [1:0] {
    SG_CMD,    // outgoing command / write frame
    SG_TURN,   // turnaround pulses of a read
    SG_CAPT,   // incoming read data
    SG_TRAIL   // trailing pulses before release
  } seg_e;

endpackage

// File: rtl/serreg_timer.sv
module serreg_timer #(
  parameter int CW      = 9,
  parameter int MAX_CYC = 300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R6: a phase never lasts longer than the largest programmed time
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) <= 32'(MAX_CYC - 1)));

  // R6: without a reload the count only falls
  p_cnt_falls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/serreg_frame.sv
module serreg_frame
  import serreg_pkg::*;
#(
  parameter int FRAME_W = RD_CMD_BITS
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [FRAME_W-1:0] frame,
  output logic [BC_W-1:0]   nbits
);

  logic [FRAME_W-1:0] rd_frame;
  logic [FRAME_W-1:0] wr_frame;

  // Read command: preamble, start 01, opcode 10, table 0, device 00, 7-bit address
  assign rd_frame = {{PREAMBLE_BITS{1'b1}}, 2'b01, 2'b10, 1'b0, 2'b00, addr[ADDR_W-2:0]};

  // Write command: start 1, opcode 01, 8-bit address, 16-bit data, left aligned
  assign wr_frame = {1'b1, 2'b01, addr, wdata, {(FRAME_W - WR_CMD_BITS){1'b0}}};

  always_comb begin
    if (wr) begin
      frame = wr_frame;
      nbits = BC_W'(WR_CMD_BITS);
    end else begin
      frame = rd_frame;
      nbits = BC_W'(RD_CMD_BITS);
    end
  end

endmodule

// File: rtl/serreg_capture.sv
module serreg_capture #(
  parameter int CAPT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              sd_in,
  output logic [CAPT_W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (clear) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {word[CAPT_W-2:0], sd_in};
    end
  end

  // R2: the first bit received ends up as the most significant bit
  p_shift_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clear) |=> (word[0] == $past(sd_in)));

endmodule

// File: rtl/serreg_master.sv
module serreg_master
  import serreg_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int EDGE_US  = 3,
  parameter int SETUP_US = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic              cs_o,
  output logic              cs_oe,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              sd_o,
  output logic              sd_oe,
  input  logic              sd_i
);

  localparam int EDGE_CYC  = CLK_MHZ * EDGE_US;
  localparam int SETUP_CYC = CLK_MHZ * SETUP_US;
  localparam int TMAX      = (EDGE_CYC > SETUP_CYC) ? EDGE_CYC : SETUP_CYC;
  localparam int TW        = (TMAX < 2) ? 1 : $clog2(TMAX);
  localparam int PCW       = (EXTRA_CLKS < 2) ? 1 : $clog2(EXTRA_CLKS);
  localparam int FRAME_W   = RD_CMD_BITS;

  phase_e              phase_q, phase_d;
  seg_e                seg_q;
  logic [FRAME_W-1:0]  tx_q;
  logic [BC_W-1:0]     bits_left_q;
  logic [PCW-1:0]      pulse_q;
  logic                wr_q, odd_q;
  logic                cs_q, sd_q, sd_oe_q, drive_q, done_q;
  logic [REG_W-1:0]    rdata_q;

  logic                start, expired, tmr_load, last_pulse;
  logic [TW-1:0]       tmr_val;
  logic [FRAME_W-1:0]  frame;
  logic [BC_W-1:0]     nbits;
  logic [CAPT_BITS-1:0] capt_word;
  logic                capt_shift;

  assign start      = (phase_q == PH_IDLE) && req_valid;
  assign last_pulse = (pulse_q == PCW'(EXTRA_CLKS - 1));

  serreg_frame #(.FRAME_W(FRAME_W)) u_frame (
    .wr    (req_write),
    .addr  (req_addr),
    .wdata (req_wdata),
    .frame (frame),
    .nbits (nbits)
  );

  serreg_timer #(.CW(TW), .MAX_CYC(TMAX)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  assign capt_shift = (phase_q == PH_LOW) && expired && (seg_q == SG_CAPT);

  serreg_capture #(.CAPT_W(CAPT_BITS)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .shift_en (capt_shift),
    .sd_in    (sd_i),
    .word     (capt_word)
  );

  // Next phase
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (req_valid) phase_d = PH_LEAD;
      PH_LEAD:  if (expired)   phase_d = PH_LOW;
      PH_LOW:   if (expired)   phase_d = PH_SETUP;
      PH_SETUP: if (expired)   phase_d = PH_HIGH;
      PH_HIGH:  if (expired)   phase_d = (bits_left_q == BC_W'(1)) ? PH_TAIL : PH_LOW;
      PH_TAIL:  if (expired)   phase_d = PH_PHIGH;
      PH_PHIGH: if (expired)   phase_d = PH_PLOW;
      PH_PLOW: begin
        if (expired) begin
          if (!last_pulse)            phase_d = PH_PHIGH;
          else if (seg_q == SG_TURN)  phase_d = PH_LEAD;
          else                        phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    tmr_load = (phase_d != phase_q);
    tmr_val  = (phase_d == PH_SETUP) ? TW'(SETUP_CYC - 1) : TW'(EDGE_CYC - 1);
  end

  // Sequencer state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      seg_q       <= SG_CMD;
      tx_q        <= '0;
      bits_left_q <= '0;
      pulse_q     <= '0;
      wr_q        <= 1'b0;
      odd_q       <= 1'b0;
      cs_q        <= 1'b0;
      sd_q        <= 1'b0;
      sd_oe_q     <= 1'b0;
      drive_q     <= 1'b0;
      done_q      <= 1'b0;
      rdata_q     <= '0;
    end else begin
      phase_q <= phase_d;
      done_q  <= 1'b0;
      if (start) begin
        tx_q        <= frame;
        bits_left_q <= nbits;
        wr_q        <= req_write;
        odd_q       <= req_addr[0];
        seg_q       <= SG_CMD;
        cs_q        <= req_write;
        sd_q        <= 1'b0;
        sd_oe_q     <= 1'b1;
        drive_q     <= 1'b1;
      end else if (expired) begin
        unique case (phase_q)
          PH_LOW: begin
            if (seg_q == SG_CMD) begin
              sd_q <= tx_q[FRAME_W-1];
              tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end
          end
          PH_HIGH: bits_left_q <= bits_left_q - 1'b1;
          PH_TAIL: begin
            pulse_q <= '0;
            if (seg_q == SG_CMD) begin
              if (wr_q) begin
                cs_q  <= 1'b0;
                seg_q <= SG_TRAIL;
              end else begin
                sd_oe_q <= 1'b0;
                seg_q   <= SG_TURN;
              end
            end else begin
              seg_q <= SG_TRAIL;
            end
          end
          PH_PLOW: begin
            if (!last_pulse) begin
              pulse_q <= pulse_q + 1'b1;
            end else if (seg_q == SG_TURN) begin
              seg_q       <= SG_CAPT;
              bits_left_q <= BC_W'(CAPT_BITS);
            end else begin
              drive_q <= 1'b0;
              sd_oe_q <= 1'b0;
              done_q  <= 1'b1;
              if (!wr_q) begin
                rdata_q <= odd_q ? capt_word[CAPT_BITS-1 -: REG_W] : capt_word[REG_W-1:0];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign rsp_valid = done_q;
  assign rsp_rdata = rdata_q;
  assign cs_o      = cs_q;
  assign cs_oe     = drive_q;
  assign sck_o     = (phase_q == PH_HIGH) || (phase_q == PH_PHIGH);
  assign sck_oe    = drive_q;
  assign sd_o      = sd_q;
  assign sd_oe     = sd_oe_q;

  // R8: an accepted request drives all three lines with clock and data low
  p_accept_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cs_oe && sck_oe && sd_oe && !sck_o && !sd_o));

  // R9: the pins are released whenever the block is ready for a request
  p_ready_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!sck_oe && !sd_oe));

  // R10: the completion pulse lasts a single cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: read data moves only together with a completion pulse
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata));

  // R6: data does not move while the clock stays high
  p_sd_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(sd_o));

  // R4: chip select does not move while the clock stays high
  p_cs_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(cs_o));

  // R2: the data line stays released while reply bits come in
  p_capt_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SG_CAPT) |-> !sd_oe);

endmodule

// File: tb/serreg_master_bench.sv
module serreg_master_bench;

  localparam int CLK_MHZ  = 2;
  localparam int EDGE_US  = 3;
  localparam int SETUP_US = 1;
  localparam int E = CLK_MHZ * EDGE_US;
  localparam int S = CLK_MHZ * SETUP_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        cs_o, cs_oe, sck_o, sck_oe, sd_o, sd_oe;
  logic        sd_i = 1'b0;

  serreg_master #(.CLK_MHZ(CLK_MHZ), .EDGE_US(EDGE_US), .SETUP_US(SETUP_US)) u_serreg_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cs_o(cs_o), .cs_oe(cs_oe), .sck_o(sck_o), .sck_oe(sck_oe),
    .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Expected pin vector per cycle: {ready, done, cs_oe, cs, sck_oe, sck, sd_oe, sd}
  logic [7:0]  expq[$];
  string       tagq[$];
  logic [15:0] rdq[$];
  logic [15:0] exp_rdata = '0;

  // Switch-side slave model
  logic [31:0] pair = '0;
  bit          slave_rd = 1'b0;
  int          rise_cnt = 0;
  logic        prev_sck = 1'b0;

  function automatic logic [15:0] wordf(logic [6:0] a);
    return 16'hC3A5 ^ {a, 1'b0, ~a, 1'b1};
  endfunction

  function automatic logic [7:0] ent(logic cs, logic sck, logic sdoe, logic sd);
    return {2'b00, 1'b1, cs, 1'b1, sck, sdoe, sd};
  endfunction

  task automatic put(int n, logic [7:0] v, string t);
    repeat (n) begin
      expq.push_back(v);
      tagq.push_back(t);
    end
  endtask

  task automatic pulses(logic sdoe, logic sd, string t);
    repeat (2) begin
      put(E, ent(1'b0, 1'b1, sdoe, sd), t);
      put(E, ent(1'b0, 1'b0, sdoe, sd), t);
    end
  endtask

  task automatic build(bit wr, logic [7:0] a, logic [15:0] d);
    logic [45:0] f;
    int n;
    logic prev;
    logic cs;
    if (wr) begin
      f = {1'b1, 2'b01, a, d, 19'd0};
      n = 27;
    end else begin
      f = {{32{1'b1}}, 2'b01, 2'b10, 1'b0, 2'b00, a[6:0]};
      n = 46;
    end
    cs = wr;
    prev = 1'b0;
    put(E, ent(cs, 1'b0, 1'b1, 1'b0), "R8");
    for (int i = 0; i < n; i++) begin
      logic b;
      b = f[45-i];
      put(E, ent(cs, 1'b0, 1'b1, prev), wr ? "R4" : "R1");
      put(S, ent(cs, 1'b0, 1'b1, b), "R6");
      put(E, ent(cs, 1'b1, 1'b1, b), wr ? "R4" : "R1");
      prev = b;
    end
    put(E, ent(cs, 1'b0, 1'b1, prev), "R7");
    if (wr) begin
      pulses(1'b1, prev, "R5");
      rdq.push_back(exp_rdata);
    end else begin
      pulses(1'b0, 1'b0, "R2");
      put(E, ent(1'b0, 1'b0, 1'b0, 1'b0), "R7");
      for (int i = 0; i < 32; i++) begin
        put(E, ent(1'b0, 1'b0, 1'b0, 1'b0), "R2");
        put(S, ent(1'b0, 1'b0, 1'b0, 1'b0), "R6");
        put(E, ent(1'b0, 1'b1, 1'b0, 1'b0), "R2");
      end
      put(E, ent(1'b0, 1'b0, 1'b0, 1'b0), "R7");
      pulses(1'b0, 1'b0, "R2");
      rdq.push_back(wordf(a[6:0]));
    end
    put(1, 8'hC0, "R10");
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step();
    logic [7:0] e, got, m;
    string t;
    @(negedge clk);
    if (sck_o && !prev_sck) rise_cnt++;
    prev_sck = sck_o;
    sd_i = (slave_rd && rise_cnt >= 48 && rise_cnt < 80) ? pair[79-rise_cnt] : 1'b0;
    if (expq.size() > 0) begin
      e = expq.pop_front();
      t = tagq.pop_front();
      if (e[6]) exp_rdata = rdq.pop_front();
    end else begin
      e = 8'h80;
      t = "R9";
    end
    got = {req_ready, rsp_valid, cs_oe, cs_o, sck_oe, sck_o, sd_oe, sd_o};
    m = 8'hFF;
    if (!e[5]) m[4] = 1'b0;
    if (!e[3]) m[2] = 1'b0;
    if (!e[1]) m[0] = 1'b0;
    chk((got & m) == (e & m), t, 32'(got & m), 32'(e & m));
    chk(rsp_rdata == exp_rdata, "R10 rdata", 32'(rsp_rdata), 32'(exp_rdata));
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic issue(bit wr, logic [7:0] a, logic [15:0] d, bit junk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    pair      = {wordf(a[6:0] | 7'h01), wordf(a[6:0] & 7'h7E)};
    slave_rd  = !wr;
    rise_cnt  = 0;
    build(wr, a, d);
    step();
    if (junk) begin
      // R9: a different request held while busy must change nothing
      req_write = ~wr;
      req_addr  = ~a;
      req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    while (expq.size() > 0) begin
      step();
      if (expq.size() <= 2) req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R8: after reset all link pins are released and the block is ready
    chk(!cs_oe && !sck_oe && !sd_oe && req_ready, "R8 reset",
        {28'd0, cs_oe, sck_oe, sd_oe, req_ready}, 32'h1);
    issue(1'b1, 8'hA5, 16'h3C5A, 1'b0);
    idle(3);
    issue(1'b0, 8'h93, 16'h0000, 1'b0);
    chk(rsp_rdata == wordf(7'h13), "R3 odd half", 32'(rsp_rdata), 32'(wordf(7'h13)));
    idle(2);
    issue(1'b0, 8'h2C, 16'h0000, 1'b0);
    chk(rsp_rdata == wordf(7'h2C), "R3 even half", 32'(rsp_rdata), 32'(wordf(7'h2C)));
    issue(1'b1, 8'h00, 16'hFFFF, 1'b0);
    chk(rsp_rdata == wordf(7'h2C), "R10 write keeps rdata", 32'(rsp_rdata), 32'(wordf(7'h2C)));
    issue(1'b0, 8'h01, 16'h1234, 1'b1);
    chk(rsp_rdata == wordf(7'h01), "R9 busy request ignored", 32'(rsp_rdata), 32'(wordf(7'h01)));
    issue(1'b0, 8'h7E, 16'h0000, 1'b0);
    issue(1'b1, 8'hFF, 16'h8001, 1'b1);
    issue(1'b0, 8'h00, 16'h0000, 1'b0);
    chk(rsp_rdata == wordf(7'h00), "R3 address zero", 32'(rsp_rdata), 32'(wordf(7'h00)));
    idle(4);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog expired actual=busy expected=idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule